// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit architectural registers of a processor core that runs in several privilege modes. Some registers exist in more than one physical copy, and the current mode decides which copy an access reaches. The stack pointer and link register (indexes 13 and 14) have their own copy in every exception mode. Indexes 8 to 12 have a second copy that only the fast-interrupt mode uses. Indexes 0 to 7 and the program counter at index 15 are single registers that every mode shares.

There are two access paths. The normal path reads and writes whatever copy the current mode selects. The user-bank path always reaches the copies that user code sees. A privileged handler uses it to save or restore a user context without leaving its own mode. Reads on both paths are combinational. Writes take effect on the rising clock edge. A mode change redirects both paths in the cycle the mode input changes, and it never moves or loses any stored value.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low reset, every physical register copy reads as zero on both ports.
- R2: Indexes 0 to 7 are a single physical set. A write in any mode, through either port, is seen at the same index in every mode and on both ports.
- R3: On the normal port, indexes 8 to 12 reach a private copy in fast-interrupt mode (mode code 1). Every other mode shares the user copy.
- R4: On the normal port, indexes 13 and 14 select one copy per mode from the 3-bit mode input: 0 user, 1 fast-interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system. System mode (6) shares the user copy.
- R5: The user-bank port always reaches the user copy of indexes 13 and 14, whatever the current mode.
- R6: On the user-bank port, indexes 8 to 12 reach the fast-interrupt copy when the mode is 1, and the user copy in every other mode.
- R7: A normal-port write to index 15 stores the data with bit 0 cleared. A normal-port read of index 15 returns the stored program counter.
- R8: Index 15 is illegal on the user-bank port. A read of it returns zero, and a write to it must not be issued.
- R9: A mode change redirects both ports combinationally, in the same cycle, and leaves every stored copy unchanged.
- R10: Both ports may write in the same cycle when they target different physical registers, and both writes take effect. Writes by the two ports to one physical register in the same cycle are forbidden.
- R11: Mode code 7 behaves as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all copies |
| mode | input | 3 | Current privilege mode code |
| rd_idx | input | 4 | Normal-port read index |
| rd_data | output | 32 | Normal-port read data |
| wr_en | input | 1 | Normal-port write enable |
| wr_idx | input | 4 | Normal-port write index |
| wr_data | input | 32 | Normal-port write data |
| usr_rd_idx | input | 4 | User-bank-port read index |
| usr_rd_data | output | 32 | User-bank-port read data |
| usr_wr_en | input | 1 | User-bank-port write enable |
| usr_wr_idx | input | 4 | User-bank-port write index |
| usr_wr_data | input | 32 | User-bank-port write data |

## Verification
The hardest situation to reach is a bank that has to keep its value while other modes write their own copies of the same index. A single read cannot tell a correct bank from one that aliases another. The stimulus first writes a different value to index 13 in each of the six banked modes, and the fast-interrupt and user copies of index 8. It then walks the mode input across all codes, including system and code 7, and reads every copy back through both ports. It ends with a same-cycle write on both ports in supervisor mode, then checks that the user copy changed and the supervisor copy did not.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic [3:0]   rd_idx,
  output logic [W-1:0] rd_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic [3:0]   usr_rd_idx,
  output logic [W-1:0] usr_rd_data,
  input  logic         usr_wr_en,
  input  logic [3:0]   usr_wr_idx,
  input  logic [W-1:0] usr_wr_data
);
  localparam logic [2:0] M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
                         M_ABT = 3'd4, M_UND = 3'd5;
  localparam int NBANK   = 6;
  localparam int FIQ_LO  = 13;
  localparam int SP_LO   = FIQ_LO + 5;
  localparam int LR_LO   = SP_LO + NBANK;
  localparam int PC_SLOT = LR_LO + NBANK;
  localparam int NPHYS   = PC_SLOT + 1;
  localparam int AW      = $clog2(NPHYS);

  function automatic int bank_of(input logic [2:0] m);
    case (m)
      M_FIQ:   return 1;
      M_IRQ:   return 2;
      M_SVC:   return 3;
      M_ABT:   return 4;
      M_UND:   return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] phys(input logic [3:0] idx, input logic [2:0] m,
                                         input logic usr);
    int b;
    b = usr ? 0 : bank_of(m);
    if (idx < 4'd8)        return AW'(idx);
    else if (idx < 4'd13)  return (m == M_FIQ) ? AW'(FIQ_LO + int'(idx) - 8) : AW'(idx);
    else if (idx == 4'd13) return AW'(SP_LO + b);
    else if (idx == 4'd14) return AW'(LR_LO + b);
    else                   return AW'(PC_SLOT);
  endfunction

  logic [W-1:0]  regs [NPHYS];
  logic [AW-1:0] pa_rd, pa_wr, pa_urd, pa_uwr;
  logic          armed;

  assign pa_rd  = phys(rd_idx, mode, 1'b0);
  assign pa_wr  = phys(wr_idx, mode, 1'b0);
  assign pa_urd = phys(usr_rd_idx, mode, 1'b1);
  assign pa_uwr = phys(usr_wr_idx, mode, 1'b1);

  assign rd_data     = regs[pa_rd];
  assign usr_rd_data = (usr_rd_idx == 4'd15) ? '0 : regs[pa_urd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (wr_en)
        regs[pa_wr] <= (wr_idx == 4'd15) ? {wr_data[W-1:1], 1'b0} : wr_data;
      if (usr_wr_en && usr_wr_idx != 4'd15)
        regs[pa_uwr] <= usr_wr_data;
    end
  end

  assert_shared_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == usr_rd_idx && rd_idx < 4'd8) |-> rd_data == usr_rd_data);

  assert_user_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd0 || mode == 3'd6) && rd_idx == usr_rd_idx &&
     (rd_idx == 4'd13 || rd_idx == 4'd14)) |-> rd_data == usr_rd_data);

  assert_pc_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> regs[PC_SLOT][0] == 1'b0);

  assert_no_usr_pc_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr_en |-> usr_wr_idx != 4'd15);

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wr_en && !usr_wr_en) |=> regs[$past(pa_rd)] == $past(rd_data));

  assert_no_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && usr_wr_en) |-> pa_wr != pa_uwr);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  rd_idx = '0, wr_idx = '0, usr_rd_idx = '0, usr_wr_idx = '0;
  logic [31:0] rd_data, usr_rd_data, wr_data = '0, usr_wr_data = '0;
  logic        wr_en = 1'b0, usr_wr_en = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  banked_regfile dut (.clk, .rst_n, .mode, .rd_idx, .rd_data, .wr_en, .wr_idx, .wr_data,
                      .usr_rd_idx, .usr_rd_data, .usr_wr_en, .usr_wr_idx, .usr_wr_data);

  // {mode, index, write data, expected read-back}
  localparam logic [70:0] VEC [10] = '{
    {3'd0, 4'd13, 32'h1111_0013, 32'h1111_0013},
    {3'd1, 4'd13, 32'h2222_0013, 32'h2222_0013},
    {3'd2, 4'd13, 32'h3333_0013, 32'h3333_0013},
    {3'd3, 4'd13, 32'h4444_0013, 32'h4444_0013},
    {3'd4, 4'd13, 32'h5555_0013, 32'h5555_0013},
    {3'd5, 4'd13, 32'h6666_0013, 32'h6666_0013},
    {3'd0, 4'd8,  32'h0000_0808, 32'h0000_0808},
    {3'd1, 4'd8,  32'hF1F1_0808, 32'hF1F1_0808},
    {3'd0, 4'd15, 32'h0000_1235, 32'h0000_1234},
    {3'd1, 4'd2,  32'h0202_0202, 32'h0202_0202}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic uwr(input logic [2:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); mode = m; usr_wr_idx = i; usr_wr_data = d; usr_wr_en = 1'b1;
    @(negedge clk); usr_wr_en = 1'b0;
  endtask

  task automatic look(input logic [2:0] m, input logic [3:0] i, input logic [3:0] ui);
    @(negedge clk); mode = m; rd_idx = i; usr_rd_idx = ui; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look(3'd0, 4'd0, 4'd9);   chk("R1 r0", rd_data, 32'h0); chk("R1 usr r9", usr_rd_data, 32'h0);
    look(3'd3, 4'd13, 4'd14); chk("R1 svc r13", rd_data, 32'h0); chk("R1 usr r14", usr_rd_data, 32'h0);
    look(3'd0, 4'd15, 4'd0);  chk("R1 pc", rd_data, 32'h0);

    for (int k = 0; k < 10; k++) begin
      logic [2:0] m; logic [3:0] i; logic [31:0] d, e;
      {m, i, d, e} = VEC[k];
      wr(m, i, d);
      look(m, i, 4'd0);
      chk(i == 4'd13 ? "R4 table" : i == 4'd8 ? "R3 table" : i == 4'd15 ? "R7 table" : "R2 table",
          rd_data, e);
    end

    for (int m = 0; m < 6; m++) begin
      look(3'(m), 4'd13, 4'd0);
      chk("R4 bank hold", rd_data, VEC[m][31:0]);
    end
    look(3'd6, 4'd13, 4'd0); chk("R4 system uses user r13", rd_data, 32'h1111_0013);
    look(3'd7, 4'd13, 4'd0); chk("R11 code 7 as user r13", rd_data, 32'h1111_0013);
    look(3'd7, 4'd8, 4'd0);  chk("R11 code 7 user r8", rd_data, 32'h0000_0808);

    look(3'd2, 4'd8, 4'd8); chk("R3 irq r8", rd_data, 32'h0000_0808);
    chk("R6 usr r8 in irq", usr_rd_data, 32'h0000_0808);
    look(3'd1, 4'd8, 4'd8); chk("R3 fiq r8", rd_data, 32'hF1F1_0808);
    chk("R6 usr r8 in fiq", usr_rd_data, 32'hF1F1_0808);
    look(3'd3, 4'd8, 4'd8); chk("R3 svc r8", rd_data, 32'h0000_0808);
    chk("R6 usr r8 in svc", usr_rd_data, 32'h0000_0808);

    look(3'd3, 4'd13, 4'd13); chk("R5 usr r13 in svc", usr_rd_data, 32'h1111_0013);
    look(3'd1, 4'd13, 4'd13); chk("R5 usr r13 in fiq", usr_rd_data, 32'h1111_0013);
    uwr(3'd2, 4'd14, 32'hABCD_0014);
    look(3'd0, 4'd14, 4'd0); chk("R5 usr r14 write seen in user", rd_data, 32'hABCD_0014);
    look(3'd2, 4'd14, 4'd0); chk("R5 irq r14 untouched", rd_data, 32'h0);

    look(3'd0, 4'd2, 4'd2); chk("R2 r2 in user", rd_data, 32'h0202_0202);
    look(3'd4, 4'd2, 4'd2); chk("R2 usr r2 in abort", usr_rd_data, 32'h0202_0202);
    uwr(3'd1, 4'd6, 32'h0606_0606);
    look(3'd5, 4'd6, 4'd0); chk("R2 usr write r6 shared", rd_data, 32'h0606_0606);

    look(3'd3, 4'd15, 4'd15); chk("R7 pc read", rd_data, 32'h0000_1234);
    chk("R8 usr index 15 reads zero", usr_rd_data, 32'h0);

    @(negedge clk); rd_idx = 4'd13; mode = 3'd1; #1;
    chk("R9 switch to fiq same cycle", rd_data, 32'h2222_0013);
    mode = 3'd5; #1;
    chk("R9 switch to und same cycle", rd_data, 32'h6666_0013);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); mode = 3'(c);
    end
    look(3'd5, 4'd13, 4'd13);
    chk("R9 und r13 after mode walk", rd_data, 32'h6666_0013);
    chk("R9 usr r13 after mode walk", usr_rd_data, 32'h1111_0013);
    look(3'd1, 4'd8, 4'd0);  chk("R9 fiq r8 after mode walk", rd_data, 32'hF1F1_0808);

    @(negedge clk);
    mode = 3'd3; wr_idx = 4'd5; wr_data = 32'h0000_0055; wr_en = 1'b1;
    usr_wr_idx = 4'd13; usr_wr_data = 32'h7777_0013; usr_wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; usr_wr_en = 1'b0;
    look(3'd3, 4'd5, 4'd13); chk("R10 normal write r5", rd_data, 32'h0000_0055);
    chk("R10 user write r13", usr_rd_data, 32'h7777_0013);
    look(3'd3, 4'd13, 4'd0); chk("R10 svc r13 kept", rd_data, 32'h4444_0013);
    look(3'd6, 4'd13, 4'd0); chk("R10 system sees new user r13", rd_data, 32'h7777_0013);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule